// File: doc/BRIEF.md
# Privileged Exception Vector Dispatcher

This block owns the program counter, the privileged-mode flag, the saved return address and the error code of a processor core, and decides each cycle whether control is diverted into privileged handler code. Synchronous events (reset, memory fault, misalignment, undefined opcode, arithmetic trap, floating-point-disabled trap and call traps) are presented by the pipeline together with a cause code. Four asynchronous interrupt lines are filtered against a 3-bit priority level. The surviving request of highest rank is granted, and an acknowledge pulse goes back to its source.

When an event is taken, the current PC is saved with the privileged flag folded into bit 0. The PC is then loaded from a handler base address plus a computed offset, and privileged mode is entered. When no event is taken, the pipeline may redirect the PC to a new value whose bit 0 carries the mode, or advance it by one 4-byte instruction.

Top module: `exc_vector_dispatch`

## Requirements
- R1: After reset the PC equals RESET_PC, privileged mode is 1, and the return address, error code, taken flag and acknowledge are all 0.
- R2: No interrupt is granted while privileged mode is 1, whatever the priority level and requests.
- R3: Interrupt lines are irq_i[0] device, irq_i[1] timer, irq_i[2] interprocessor and irq_i[3] machine check. Level 7 accepts none, 6 accepts machine check, 5 adds interprocessor, 4 adds timer, and levels 0 to 3 accept all four.
- R4: Among accepted requests, machine check beats interprocessor, which beats timer, which beats device.
- R5: Cause codes are 0 reset, 1 memory fault, 2 unaligned, 3 illegal opcode, 4 arithmetic, 5 FP disabled, 6 call trap and 7 reserved. Their offsets are 0x000, 0x280, 0x300, 0x380, 0x400 and 0x480, and 7 uses 0x380. Interrupt offsets are machine check 0x080, interprocessor 0x100, timer 0x180 and device 0x200.
- R6: For a call trap with code bit 7 set, the offset is 0x2000 + (code-0x80)*64. Otherwise it is 0x1000 + code*64.
- R7: On the edge that takes an event, the return address becomes PC OR privileged flag. The PC becomes base_i + offset with bits 1:0 forced to 0, privileged mode and taken_o become 1, and taken_o lasts one cycle.
- R8: A taken interrupt clears the error code. A taken synchronous event loads it with exc_code_i.
- R9: A synchronous event is taken before any interrupt that is pending in the same cycle, and no interrupt is acknowledged in that cycle.
- R10: With no event, a redirect loads the PC with redir_pc_i bits 1:0 cleared and privileged mode with redir_pc_i bit 0. Otherwise adv_i adds 4 to the PC, and with neither input the PC and mode hold.
- R11: irq_ack_o is the one-hot grant of the interrupt taken at the next edge, or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ipl_i | input | 3 | Current interrupt priority level |
| irq_i | input | 4 | Interrupt requests (device, timer, interprocessor, machine check) |
| exc_valid_i | input | 1 | Synchronous event present this cycle |
| exc_cause_i | input | 3 | Cause code of the synchronous event |
| exc_code_i | input | 8 | Call-trap function code or error code |
| base_i | input | PC_W | Handler base address |
| redir_valid_i | input | 1 | Load PC and mode from redir_pc_i |
| redir_pc_i | input | PC_W | New PC, bit 0 is the mode |
| adv_i | input | 1 | Advance PC by 4 |
| pc_o | output | PC_W | Program counter |
| priv_o | output | 1 | Privileged mode flag |
| ret_addr_o | output | PC_W | Saved return address with mode in bit 0 |
| err_code_o | output | 8 | Error code |
| taken_o | output | 1 | An event was taken at the last edge |
| irq_ack_o | output | 4 | One-hot acknowledge of the granted interrupt |

## Verification
The bench builds the block with PC_W of 32 and the default reset PC. This lets it drive handler bases near the top of the address space, so that base plus offset wraps modulo 2^32. The full 8-bit call code range is reachable, so both call regions and their edges (0x00, 0x7F, 0x80, 0xFF) are exercised. Every pairing of the eight priority levels with the fifteen request patterns is swept. A long random phase follows that mixes redirects, advances, events and collisions of synchronous events with interrupts.

// File: rtl/exc_disp_pkg.sv
package exc_disp_pkg;
  localparam int N_IRQ  = 4;
  localparam int LVL_W  = 3;
  localparam int CODE_W = 8;
  localparam int OFF_W  = 14;
  localparam int SLOT   = 128;   // spacing of fixed vectors
  localparam int CALL_STRIDE_SH = 6;

  typedef enum logic [2:0] {
    CAUSE_RESET = 3'd0,
    CAUSE_MEMF  = 3'd1,
    CAUSE_UNAL  = 3'd2,
    CAUSE_OPC   = 3'd3,
    CAUSE_ARITH = 3'd4,
    CAUSE_FPDIS = 3'd5,
    CAUSE_CALL  = 3'd6,
    CAUSE_RSVD  = 3'd7
  } cause_e;
endpackage

// File: rtl/irq_select.sv
module irq_select
  import exc_disp_pkg::*;
#(
  parameter int N        = N_IRQ,
  parameter int LW       = LVL_W,
  parameter int BASE_LVL = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic [LW-1:0] lvl_i,
  input  logic          en_i,
  output logic [N-1:0]  gnt_o,
  output logic          any_o
);
  logic [N-1:0] acc;

  // line j is accepted up to level BASE_LVL+j
  for (genvar j = 0; j < N; j++) begin : g_acc
    localparam int THR = BASE_LVL + j;
    assign acc[j] = req_i[j] && (int'(lvl_i) <= THR);
  end

  logic [N-1:0] pick;
  always_comb begin
    pick = '0;
    for (int j = 0; j < N; j++) begin
      if (acc[j]) begin
        pick    = '0;
        pick[j] = 1'b1;
      end
    end
  end

  assign gnt_o = en_i ? pick : '0;
  assign any_o = |gnt_o;
endmodule

// File: rtl/vec_calc.sv
module vec_calc
  import exc_disp_pkg::*;
#(
  parameter int N  = N_IRQ,
  parameter int CW = CODE_W,
  parameter int OW = OFF_W
) (
  input  logic          irq_take_i,
  input  logic [N-1:0]  gnt_i,
  input  cause_e        cause_i,
  input  logic [CW-1:0] code_i,
  output logic [OW-1:0] off_o
);
  localparam logic [OW-1:0] CALL_LO = OW'(32'h1000);
  localparam logic [OW-1:0] CALL_HI = OW'(32'h2000);

  logic [OW-1:0] irq_off, sync_off, call_off;

  always_comb begin
    irq_off = '0;
    for (int j = 0; j < N; j++)
      if (gnt_i[j]) irq_off = OW'((N - j) * SLOT);
  end

  assign call_off = (code_i[CW-1] ? CALL_HI : CALL_LO)
                  + (OW'(code_i[CW-2:0]) << CALL_STRIDE_SH);

  always_comb begin
    unique case (cause_i)
      CAUSE_RESET: sync_off = '0;
      CAUSE_CALL:  sync_off = call_off;
      CAUSE_RSVD:  sync_off = OW'(int'(CAUSE_OPC) + 4) * OW'(SLOT);
      default:     sync_off = OW'(int'(cause_i) + 4) * OW'(SLOT);
    endcase
  end

  assign off_o = irq_take_i ? irq_off : sync_off;
endmodule

// File: rtl/disp_state.sv
module disp_state
  import exc_disp_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            take_irq_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [PC_W-1:0] base_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic            redir_valid_i,
  input  logic [PC_W-1:0] redir_pc_i,
  input  logic            adv_i,
  output logic [PC_W-1:0] pc_o,
  output logic            priv_o,
  output logic [PC_W-1:0] ret_o,
  output logic [CODE_W-1:0] err_o,
  output logic            taken_o
);
  localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(3);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  logic [PC_W-1:0] pc_q, ret_q;
  logic            priv_q, taken_q;
  logic [CODE_W-1:0] err_q;
  logic [PC_W-1:0] vec_pc;

  assign vec_pc = (base_i + PC_W'(off_i)) & ALIGN_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_PC & ALIGN_MASK;
      priv_q  <= 1'b1;
      ret_q   <= '0;
      err_q   <= '0;
      taken_q <= 1'b0;
    end else if (take_i) begin
      ret_q   <= pc_q | PC_W'(priv_q);
      pc_q    <= vec_pc;
      priv_q  <= 1'b1;
      err_q   <= take_irq_i ? '0 : code_i;
      taken_q <= 1'b1;
    end else begin
      taken_q <= 1'b0;
      if (redir_valid_i) begin
        pc_q   <= redir_pc_i & ALIGN_MASK;
        priv_q <= redir_pc_i[0];
      end else if (adv_i) begin
        pc_q   <= pc_q + INSN_BYTES;
      end
    end
  end

  assign pc_o    = pc_q;
  assign priv_o  = priv_q;
  assign ret_o   = ret_q;
  assign err_o   = err_q;
  assign taken_o = taken_q;

  assert_enter_priv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (priv_q && taken_q));
  assert_ret_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (ret_q == ($past(pc_q) | PC_W'($past(priv_q)))));
  assert_taken_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> !taken_q);
  assert_pc_aligned_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[1:0] == 2'b00);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !redir_valid_i && !adv_i) |=> ($stable(pc_q) && $stable(priv_q)));
endmodule

// File: rtl/exc_vector_dispatch.sv
module exc_vector_dispatch
  import exc_disp_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  ipl_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              exc_valid_i,
  input  logic [2:0]        exc_cause_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [PC_W-1:0]   base_i,
  input  logic              redir_valid_i,
  input  logic [PC_W-1:0]   redir_pc_i,
  input  logic              adv_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              priv_o,
  output logic [PC_W-1:0]   ret_addr_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic              taken_o,
  output logic [N_IRQ-1:0]  irq_ack_o
);
  logic [N_IRQ-1:0] gnt;
  logic             irq_any, irq_en, take;
  logic [OFF_W-1:0] off;
  cause_e           cause;

  assign cause  = cause_e'(exc_cause_i);
  assign irq_en = !priv_o && !exc_valid_i;   // sync events first
  assign take   = exc_valid_i || irq_any;

  irq_select #(.N(N_IRQ), .LW(LVL_W), .BASE_LVL(3)) u_sel (
    .req_i (irq_i),
    .lvl_i (ipl_i),
    .en_i  (irq_en),
    .gnt_o (gnt),
    .any_o (irq_any)
  );

  vec_calc #(.N(N_IRQ), .CW(CODE_W), .OW(OFF_W)) u_vec (
    .irq_take_i (irq_any),
    .gnt_i      (gnt),
    .cause_i    (cause),
    .code_i     (exc_code_i),
    .off_o      (off)
  );

  disp_state #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .take_i        (take),
    .take_irq_i    (irq_any),
    .off_i         (off),
    .base_i        (base_i),
    .code_i        (exc_code_i),
    .redir_valid_i (redir_valid_i),
    .redir_pc_i    (redir_pc_i),
    .adv_i         (adv_i),
    .pc_o          (pc_o),
    .priv_o        (priv_o),
    .ret_o         (ret_addr_o),
    .err_o         (err_code_o),
    .taken_o       (taken_o)
  );

  assign irq_ack_o = gnt;

  assert_no_irq_in_priv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_o |-> (irq_ack_o == '0));
  assert_ack_requested_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o & ~irq_i) == '0);
  assert_level7_masks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipl_i == 3'd7) |-> (irq_ack_o == '0));
  assert_sync_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |-> (irq_ack_o == '0));
  assert_ack_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_ack_o));
  assert_irq_err_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o != '0) |=> (err_code_o == '0 && priv_o));
  assert_mchk_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i[3] && !priv_o && !exc_valid_i && ipl_i != 3'd7) |-> irq_ack_o[3]);
endmodule

// File: tb/exc_vector_dispatch_tb.sv
module exc_vector_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  ipl = '0;
  logic [3:0]  irq = '0;
  logic        exc_v = 1'b0;
  logic [2:0]  cause = '0;
  logic [7:0]  code = '0;
  logic [31:0] base = '0;
  logic        rv = 1'b0;
  logic [31:0] rpc = '0;
  logic        adv = 1'b0;

  logic [31:0] pc_o, ret_o;
  logic        priv_o, taken_o;
  logic [7:0]  err_o;
  logic [3:0]  ack_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vector_dispatch #(.PC_W(PC_W), .RESET_PC('0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ipl_i(ipl), .irq_i(irq),
    .exc_valid_i(exc_v), .exc_cause_i(cause), .exc_code_i(code),
    .base_i(base), .redir_valid_i(rv), .redir_pc_i(rpc), .adv_i(adv),
    .pc_o(pc_o), .priv_o(priv_o), .ret_addr_o(ret_o),
    .err_code_o(err_o), .taken_o(taken_o), .irq_ack_o(ack_o)
  );

  // reference model
  logic [31:0] m_pc, m_ret;
  logic        m_priv, m_taken;
  logic [7:0]  m_err;

  int checks = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  function automatic logic [3:0] exp_ack(input logic p, input logic [2:0] l,
                                         input logic [3:0] r, input logic e);
    logic [3:0] okmask, a;
    if (p || e) return 4'b0000;
    case (l)
      3'd4: okmask = 4'b1110;
      3'd5: okmask = 4'b1100;
      3'd6: okmask = 4'b1000;
      3'd7: okmask = 4'b0000;
      default: okmask = 4'b1111;
    endcase
    a = r & okmask;
    if (a[3]) return 4'b1000;
    if (a[2]) return 4'b0100;
    if (a[1]) return 4'b0010;
    if (a[0]) return 4'b0001;
    return 4'b0000;
  endfunction

  function automatic logic [31:0] sync_off(input logic [2:0] c, input logic [7:0] k);
    case (c)
      3'd0: return 32'h000;
      3'd1: return 32'h280;
      3'd2: return 32'h300;
      3'd3: return 32'h380;
      3'd4: return 32'h400;
      3'd5: return 32'h480;
      3'd6: return (k >= 8'h80) ? 32'h2000 + (32'(k) - 32'h80) * 64
                                : 32'h1000 + 32'(k) * 64;
      default: return 32'h380;
    endcase
  endfunction

  function automatic logic [31:0] irq_off(input logic [3:0] g);
    case (g)
      4'b1000: return 32'h080;
      4'b0100: return 32'h100;
      4'b0010: return 32'h180;
      default: return 32'h200;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = '0; m_priv = 1'b1; m_ret = '0; m_err = '0; m_taken = 1'b0;
    end else begin
      logic [3:0] g;
      g = exp_ack(m_priv, ipl, irq, exc_v);
      if (exc_v || g != 0) begin
        m_ret   = m_pc | {31'b0, m_priv};
        m_pc    = (base + (exc_v ? sync_off(cause, code) : irq_off(g))) & ~32'd3;
        m_priv  = 1'b1;
        m_err   = exc_v ? code : 8'h00;
        m_taken = 1'b1;
      end else begin
        m_taken = 1'b0;
        if (rv) begin
          m_pc = rpc & ~32'd3; m_priv = rpc[0];
        end else if (adv) m_pc = m_pc + 4;
      end
    end
  end

  task automatic chk(input string f, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", cur_req, f, got, exp);
    end
  endtask

  task automatic compare();
    chk("pc_o", pc_o, m_pc);
    chk("priv_o", 32'(priv_o), 32'(m_priv));
    chk("ret_addr_o", ret_o, m_ret);
    chk("err_code_o", 32'(err_o), 32'(m_err));
    chk("taken_o", 32'(taken_o), 32'(m_taken));
    chk("irq_ack_o", 32'(ack_o), 32'(exp_ack(m_priv, ipl, irq, exc_v)));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    irq = '0; exc_v = 0; rv = 0; adv = 0;
  endtask

  task automatic to_user(input logic [31:0] a);
    idle(); rv = 1; rpc = a & ~32'd3; cyc(); rv = 0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1'b1;
    cyc();

    cur_req = "R10";
    rpc = 32'h0000_4001; rv = 1; cyc();          // stay privileged
    rv = 0; adv = 1; cyc(); cyc();
    adv = 0; cyc();
    to_user(32'h0000_8000);
    adv = 1; cyc(); idle(); cyc();

    cur_req = "R3 R4 R11 R8";
    base = 32'h0010_0000;
    for (int l = 0; l < 8; l++)
      for (int p = 1; p < 16; p++) begin
        to_user(32'h0002_0000 + 32'(p) * 16);
        ipl = 3'(l); irq = 4'(p); code = 8'h5A; cyc();
        idle(); cyc();
      end

    cur_req = "R2";
    rpc = 32'h0000_3001; rv = 1; cyc(); rv = 0;
    ipl = 0; irq = 4'hF; cyc(); cyc(); idle(); cyc();

    cur_req = "R5 R7 R8";
    for (int c = 0; c < 8; c++) begin
      to_user(32'h0000_1000 + 32'(c) * 8);
      exc_v = 1; cause = 3'(c); code = 8'(c + 8'h30); cyc();
      idle(); cyc();
    end
    exc_v = 1; cause = 3'd4; code = 8'h11; cyc();  // taken from privileged
    idle(); cyc();

    cur_req = "R6";
    foreach (code_list[i]) begin
      to_user(32'h0000_2000);
      exc_v = 1; cause = 3'd6; code = code_list[i]; cyc();
      idle(); cyc();
    end

    cur_req = "R9";
    to_user(32'h0000_6000);
    exc_v = 1; cause = 3'd2; code = 8'h77; ipl = 0; irq = 4'hF; cyc();
    idle(); cyc();

    cur_req = "R7";
    base = 32'hFFFF_FF83;
    to_user(32'h0000_7000);
    exc_v = 1; cause = 3'd5; code = 8'h01; cyc();
    idle(); cyc();

    cur_req = "R7 R10 R11";
    for (int n = 0; n < 3000; n++) begin
      ipl   = 3'($urandom_range(0, 7));
      irq   = 4'($urandom);
      exc_v = ($urandom_range(0, 9) == 0);
      cause = 3'($urandom);
      code  = 8'($urandom);
      base  = $urandom;
      rv    = ($urandom_range(0, 3) == 0);
      rpc   = $urandom;
      adv   = $urandom_range(0, 1);
      cyc();
    end
    idle(); cyc();

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  logic [7:0] code_list [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF};

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule